// File: doc/BRIEF.md
# Register-Amount Barrel Shifter With Carry Flag

This block is a purely combinational 32-bit shifter for an integer execution pipe. It takes an operand, a register whose least significant byte holds the shift distance, a two-bit operation select and the current carry flag. It returns the shifted word and the updated carry flag. Four operations are supported: logical left, logical right, arithmetic right and rotate right.

Register-held distances can be zero, exactly the word width, or larger than the word width. Each of these cases has its own rule for the result and the carry. Rotation reduces the distance modulo 32. A distance that is a non-zero multiple of 32 is still kept apart from a true zero. The caller sets the outputs into a flag register and a result bus on its own clock edge, so the block holds no state.

Top module: `reg_shift_carry`

## Requirements
- R1: Only bits [7:0] of `amountReg` affect the outputs. Bits [31:8] never change the result or the carry.
- R2: A distance of 0 passes `opValue` to `resultOut` and `carryIn` to `carryOut` unchanged, for every value of `shiftSel`.
- R3: With `shiftSel`=00 (logical left) and a distance n of 1..31, the result is the operand shifted left by n with zeros filled in, and the carry is operand bit 32-n.
- R4: With `shiftSel`=00 and a distance of 32 or more, the result is 0. The carry is operand bit 0 at exactly 32 and 0 above 32.
- R5: With `shiftSel`=01 (logical right) and a distance n of 1..31, the result is the operand shifted right by n with zeros filled in, and the carry is operand bit n-1.
- R6: With `shiftSel`=01 and a distance of 32 or more, the result is 0. The carry is operand bit 31 at exactly 32 and 0 above 32.
- R7: With `shiftSel`=10 (arithmetic right) and a distance n of 1..31, the result is shifted right by n with copies of bit 31 filled in, and the carry is operand bit n-1.
- R8: With `shiftSel`=10 and a distance of 32 or more, every result bit equals operand bit 31, and the carry is operand bit 31.
- R9: With `shiftSel`=11 (rotate right), a non-zero distance whose value modulo 32 is r in 1..31 rotates the operand right by r. The carry is operand bit r-1.
- R10: With `shiftSel`=11 and a distance that is a non-zero multiple of 32 (32, 64 ... 224), the result equals the operand and the carry is operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opValue | input | 32 | Operand to shift |
| amountReg | input | 32 | Register holding the distance in its low byte |
| shiftSel | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 32 | Shifted operand |
| carryOut | output | 1 | Updated carry flag |

## Verification
There are no registers between inputs and outputs, so both the result and the carry are due in the same cycle as the stimulus. The bench applies each new input set just after a rising edge. It compares both outputs at the following falling edge, once the logic has settled and well before the next stimulus. Every one of the 256 distance-byte values is swept for each operation on several operand patterns. A second pass varies only the upper bits of the distance register.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_SAR = 2'b10,
    OP_ROR = 2'b11
  } shiftOp_e;

  // Strobes from the distance decoder to the datapath, sized for up to 64-bit words
  typedef struct packed {
    shiftOp_e   kind;
    logic       inRange;   // effective distance 1..W-1
    logic       atWidth;   // distance exactly W (non-rotate)
    logic       bigAmt;    // distance W or larger (non-rotate)
    logic       rotWrap;   // rotate, non-zero multiple of W
    logic [5:0] shAmt;     // effective distance within a word
  } shiftCtl_t;
endpackage

// File: rtl/shift_ctl.sv
module shift_ctl
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [AMT_W-1:0] amt,
  input  logic [1:0]       sel,
  output shiftCtl_t        strb
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

  logic [IDX_W-1:0] lowBits;
  logic             amtNonZero;

  assign lowBits    = amt[IDX_W-1:0];
  assign amtNonZero = (amt != '0);

  always_comb begin
    strb         = '0;
    strb.kind    = shiftOp_e'(sel);
    strb.shAmt   = 6'(lowBits);
    if (strb.kind == OP_ROR) begin
      strb.inRange = (lowBits != '0);
      strb.rotWrap = amtNonZero && (lowBits == '0);
    end else begin
      strb.inRange = amtNonZero && (amt < WIDTH_AMT);
      strb.atWidth = (amt == WIDTH_AMT);
      strb.bigAmt  = (amt >= WIDTH_AMT);
    end
  end

  // R2 / R10: at most one distance class is active at a time
  always_comb begin
    p_one_class_r10: assert ($onehot0({strb.inRange, strb.rotWrap, strb.bigAmt}))
      else $error("distance classes overlap");
    // R2: a zero distance selects no class at all
    if (!amtNonZero)
      p_zero_no_class_r2: assert (!strb.inRange && !strb.rotWrap && !strb.bigAmt)
        else $error("zero distance decoded as active");
  end
endmodule

// File: rtl/shift_dp.sv
module shift_dp
  import shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val,
  input  logic              cin,
  input  shiftCtl_t         strb,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] sAmt;
  logic [IDX_W-1:0] loIdx;
  logic [IDX_W-1:0] hiIdx;
  logic             signBit;

  assign sAmt    = strb.shAmt[IDX_W-1:0];
  assign loIdx   = IDX_W'(int'(sAmt) - 1);
  assign hiIdx   = IDX_W'(DATA_W - int'(sAmt));
  assign signBit = val[DATA_W-1];

  always_comb begin
    res  = val;
    cout = cin;
    if (strb.inRange) begin
      unique case (strb.kind)
        OP_SHL: begin res = val << sAmt;                              cout = val[hiIdx]; end
        OP_SHR: begin res = val >> sAmt;                              cout = val[loIdx]; end
        OP_SAR: begin res = DATA_W'($signed(val) >>> sAmt);           cout = val[loIdx]; end
        OP_ROR: begin res = (val >> sAmt) | (val << (DATA_W - int'(sAmt))); cout = val[loIdx]; end
      endcase
    end else if (strb.rotWrap) begin
      res  = val;
      cout = signBit;
    end else if (strb.bigAmt) begin
      unique case (strb.kind)
        OP_SHL:  begin res = '0; cout = strb.atWidth ? val[0] : 1'b0; end
        OP_SHR:  begin res = '0; cout = strb.atWidth ? signBit : 1'b0; end
        default: begin res = {DATA_W{signBit}}; cout = signBit; end
      endcase
    end
  end

  always_comb begin
    if (!strb.inRange && !strb.rotWrap && !strb.bigAmt)
      p_zero_pass_r2: assert (res == val && cout == cin) else $error("zero distance altered data");
    if (strb.bigAmt && strb.kind == OP_SHL)
      p_shl_clear_r4: assert (res == '0) else $error("left shift past width not cleared");
    if (strb.bigAmt && strb.kind == OP_SAR)
      p_sar_fill_r8: assert ((res == '0 || res == '1) && res[0] == val[DATA_W-1] && cout == val[DATA_W-1])
        else $error("arithmetic fill wrong");
    if (strb.inRange && strb.kind == OP_ROR)
      p_ror_keep_r9: assert ($countones(res) == $countones(val)) else $error("rotate lost bits");
    if (strb.rotWrap)
      p_ror_wrap_r10: assert (res == val && cout == val[DATA_W-1]) else $error("rotate wrap wrong");
  end
endmodule

// File: rtl/reg_shift_carry.sv
module reg_shift_carry
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] opValue,
  input  logic [DATA_W-1:0] amountReg,
  input  logic [1:0]        shiftSel,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut
);
  shiftCtl_t ctlStrb;

  // R1: only the low byte reaches the decoder
  shift_ctl #(.DATA_W(DATA_W), .AMT_W(AMT_W)) uCtl (
    .amt  (amountReg[AMT_W-1:0]),
    .sel  (shiftSel),
    .strb (ctlStrb)
  );

  shift_dp #(.DATA_W(DATA_W)) uDp (
    .val  (opValue),
    .cin  (carryIn),
    .strb (ctlStrb),
    .res  (resultOut),
    .cout (carryOut)
  );
endmodule

// File: tb/reg_shift_carry_test.sv
module reg_shift_carry_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opValue = '0;
  logic [31:0] amountReg = '0;
  logic [1:0]  shiftSel = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic        carryOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reg_shift_carry uut (
    .opValue(opValue), .amountReg(amountReg), .shiftSel(shiftSel),
    .carryIn(carryIn), .resultOut(resultOut), .carryOut(carryOut)
  );

  // Behavioural reference: one bit position per step
  function automatic logic [32:0] refModel(logic [31:0] v, logic [7:0] n, logic [1:0] op, logic c);
    logic [31:0] r = v;
    logic        k = c;
    for (int i = 0; i < int'(n); i++) begin
      case (op)
        2'b00: begin k = r[31]; r = {r[30:0], 1'b0}; end
        2'b01: begin k = r[0];  r = {1'b0, r[31:1]}; end
        2'b10: begin k = r[0];  r = {r[31], r[31:1]}; end
        default: begin k = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {k, r};
  endfunction

  function automatic string reqTag(logic [7:0] n, logic [1:0] op);
    if (n == 0) return "R2";
    case (op)
      2'b00: return (n < 32) ? "R3" : "R4";
      2'b01: return (n < 32) ? "R5" : "R6";
      2'b10: return (n < 32) ? "R7" : "R8";
      default: return (n[4:0] != 0) ? "R9" : "R10";
    endcase
  endfunction

  task automatic applyCheck(logic [31:0] v, logic [31:0] a, logic [1:0] op, logic c, string tag);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    opValue = v; amountReg = a; shiftSel = op; carryIn = c;
    exp = refModel(v, a[7:0], op, c);
    @(negedge clk);
    checks++;
    if ({carryOut, resultOut} !== exp) begin
      errors++;
      $display("FAIL %s: v=%h amt=%h op=%0d cin=%0b actual res=%h c=%0b expected res=%h c=%0b",
               tag, v, a, op, c, resultOut, carryOut, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'hAAAA_AAAA;
    pats[2] = 32'h5555_5555;
    pats[3] = 32'h8000_1234;
    pats[4] = 32'h0F00_00F1;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset-state check: all-zero inputs give all-zero outputs (R2)
    @(negedge clk);
    checks++;
    if (resultOut !== 32'h0 || carryOut !== 1'b0) begin
      errors++;
      $display("FAIL R2: idle actual res=%h c=%0b expected res=0 c=0", resultOut, carryOut);
    end
    for (int p = 0; p < 5; p++)
      for (int op = 0; op < 4; op++)
        for (int n = 0; n < 256; n++)
          applyCheck(pats[p], {24'h000000, 8'(n)}, 2'(op), 1'((p + n) & 1), reqTag(8'(n), 2'(op)));
    // R1: upper register bits must not matter
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 256; n += 7) begin
        applyCheck(32'h8123_4567, {24'hFFFFFF, 8'(n)}, 2'(op), 1'b1, "R1");
        applyCheck(32'h8123_4567, {24'hA5_5A_C3, 8'(n)}, 2'(op), 1'b0, "R1");
      end
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule